// File: doc/BRIEF.md
# Conditional Skip Evaluator

This block judges one instruction of the skip class on a 24-bit machine and produces the program counter that follows it. An instruction belongs to the class when its five most significant bits carry a fixed code. Within such a word, a set of select bits picks tests on the accumulator, the in-out register and the overflow flag. Eight further bits pick front-panel sense switches. A test or switch that is selected and true makes the raw decision true. A single invert bit can flip that decision. When the final decision is to skip, the counter moves two words ahead instead of one.

Every accepted instruction yields its result in the clock cycle after it is presented. That result has three parts: the next counter value, a strobe saying the result is valid, and a one-cycle pulse that tells the flag logic to clear overflow whenever the overflow test was among the selected tests. Other instruction classes are not handled here, and neither is debouncing the switches.

Bit numbering below follows the machine's convention, where bit 0 is the most significant bit of the word. Bit k of the instruction is therefore `instWord[23-k]`.

Top module: `skip_eval_top`

## Requirements
- R1: A result is produced only when `instValid` is high and bits 0..4 (`instWord[23:19]`) equal 1,1,0,1,0; bit 5 does not matter. `resultValid` is high in the following cycle only. A word from another class, or a cycle with `instValid` low, leaves `resultValid` low and `pcNext` unchanged.
- R2: Bit 15 (`instWord[8]`) selects the test "accumulator equals zero".
- R3: Bit 14 (`instWord[9]`) selects the test "accumulator non-negative", meaning its bit 0 (`acc[23]`) is 0.
- R4: Bit 13 (`instWord[10]`) selects the test "accumulator negative", meaning `acc[23]` is 1.
- R5: Bit 12 (`instWord[11]`) selects the test "overflow flag clear".
- R6: Bit 11 (`instWord[12]`) selects the test "in-out register non-negative", meaning `ioReg[23]` is 0.
- R7: Bit `instWord[k]` (k = 0..7) selects sense switch `senseSw[k]`, which counts as true when it is 1.
- R8: The raw decision is the OR of every selected test and every selected switch. It is false when nothing is selected.
- R9: Bit 6 (`instWord[17]`) inverts the raw decision. With nothing selected, the inverted form always skips.
- R10: `pcNext` is `pcIn + 2` on a skip and `pcIn + 1` otherwise, taken modulo 2^16.
- R11: `ovClear` pulses high for exactly the result cycle of an accepted instruction that selected the overflow test, whatever the decision was. It stays low at all other times.
- R12: While reset is held, and after reset, `resultValid`, `ovClear` and `pcNext` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | The instruction word on this cycle is to be evaluated |
| instWord | input | 24 | Instruction word, bit 0 is the MSB |
| acc | input | 24 | Accumulator value |
| ioReg | input | 24 | In-out register value |
| ovFlag | input | 1 | Current overflow flag |
| senseSw | input | 8 | Sense switch levels |
| pcIn | input | 16 | Counter value of the instruction being evaluated |
| pcNext | output | 16 | Counter value that follows the instruction |
| resultValid | output | 1 | `pcNext` and `ovClear` belong to an accepted instruction |
| ovClear | output | 1 | Pulse requesting that overflow be cleared |

## Verification
Each result passes through one register level. So `pcNext`, `resultValid` and `ovClear` are due at the first rising edge after `instValid` is sampled high, and no later. The bench changes its inputs on falling edges. It reads the outputs 1 ns after that rising edge and compares them with values worked out from the requirements. It then removes the instruction and reads the outputs again one cycle later. This confirms that the valid strobe and the overflow pulse have dropped and that `pcNext` holds its value. Words from other classes, and cycles with no instruction, are checked through the same two reads.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;

  // Opcode that marks the skip class, held in the five MSBs of the word.
  localparam logic [4:0] SKIP_GROUP_CODE = 5'b11010;

  // Positions within the word, using LSB-0 indexing. The neighbouring
  // decode depends on these positions, so they are fixed here.
  localparam int OP_MSB   = 23;
  localparam int OP_LSB   = 19;
  localparam int INV_POS  = 17;
  localparam int IOPOS_BIT = 12;
  localparam int OVCLR_BIT = 11;
  localparam int ACNEG_BIT = 10;
  localparam int ACPOS_BIT = 9;
  localparam int ACZ_BIT   = 8;

  // Strobes that the control module sends to the datapath.
  typedef struct packed {
    logic load;    // capture a new result
    logic clrOv;   // request an overflow clear
    logic doSkip;  // advance by two
  } ctlStrobes_t;

endpackage

// File: rtl/skip_eval_ctl.sv
module skip_eval_ctl
  import skip_eval_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SW_W   = 8
) (
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] ioReg,
  input  logic              ovFlag,
  input  logic [SW_W-1:0]   senseSw,
  output ctlStrobes_t       strobes
);

  localparam int SIGN_POS = WORD_W - 1;

  logic            isGroup;
  logic            invSel;
  logic            accZero;
  logic            accNeg;
  logic            ioNeg;
  logic [4:0]      condHit;
  logic [SW_W-1:0] swHit;
  logic            rawSkip;
  logic            unusedFields;

  assign isGroup = (instWord[OP_MSB:OP_LSB] == SKIP_GROUP_CODE);
  assign invSel  = instWord[INV_POS];
  assign accZero = (acc == '0);
  assign accNeg  = acc[SIGN_POS];
  assign ioNeg   = ioReg[SIGN_POS];

  // Each register or flag test is qualified by its own select bit.
  assign condHit[0] = instWord[ACZ_BIT]   & accZero;
  assign condHit[1] = instWord[ACPOS_BIT] & ~accNeg;
  assign condHit[2] = instWord[ACNEG_BIT] & accNeg;
  assign condHit[3] = instWord[OVCLR_BIT] & ~ovFlag;
  assign condHit[4] = instWord[IOPOS_BIT] & ~ioNeg;

  // One AND term per sense switch.
  for (genvar k = 0; k < SW_W; k++) begin : g_sw
    assign swHit[k] = instWord[k] & senseSw[k];
  end

  assign rawSkip = (|condHit) | (|swHit);

  // Word bits that this class does not decode.
  assign unusedFields = ^{instWord[18], instWord[16:13]};

  always_comb begin
    strobes        = '0;
    strobes.load   = instValid & isGroup;
    strobes.clrOv  = strobes.load & instWord[OVCLR_BIT];
    strobes.doSkip = strobes.load & (rawSkip ^ invSel);
  end

endmodule

// File: rtl/skip_eval_dp.sv
module skip_eval_dp
  import skip_eval_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     strobes,
  input  logic [PC_W-1:0] pcIn,
  output logic [PC_W-1:0] pcNext,
  output logic            resultValid,
  output logic            ovClear
);

  localparam logic [PC_W-1:0] STEP_ONE = PC_W'(1);
  localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2);

  logic [PC_W-1:0] pcStep;
  logic [PC_W-1:0] pcSum;

  assign pcStep = strobes.doSkip ? STEP_TWO : STEP_ONE;
  assign pcSum  = pcIn + pcStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcNext      <= '0;
      resultValid <= 1'b0;
      ovClear     <= 1'b0;
    end else begin
      resultValid <= strobes.load;
      ovClear     <= strobes.clrOv;
      if (strobes.load) pcNext <= pcSum;
    end
  end

endmodule

// File: rtl/skip_eval_top.sv
module skip_eval_top
  import skip_eval_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int PC_W   = 16,
  parameter int SW_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] ioReg,
  input  logic              ovFlag,
  input  logic [SW_W-1:0]   senseSw,
  input  logic [PC_W-1:0]   pcIn,
  output logic [PC_W-1:0]   pcNext,
  output logic              resultValid,
  output logic              ovClear
);

  ctlStrobes_t strobes;

  skip_eval_ctl #(.WORD_W(WORD_W), .SW_W(SW_W)) ctl_i (
    .instValid(instValid),
    .instWord (instWord),
    .acc      (acc),
    .ioReg    (ioReg),
    .ovFlag   (ovFlag),
    .senseSw  (senseSw),
    .strobes  (strobes)
  );

  skip_eval_dp #(.PC_W(PC_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pcIn       (pcIn),
    .pcNext     (pcNext),
    .resultValid(resultValid),
    .ovClear    (ovClear)
  );

endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
  parameter int WORD_W = 24,
  parameter int PC_W   = 16,
  parameter int SW_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [WORD_W-1:0] instWord,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] ioReg,
  input logic              ovFlag,
  input logic [SW_W-1:0]   senseSw,
  input logic [PC_W-1:0]   pcIn,
  input logic [PC_W-1:0]   pcNext,
  input logic              resultValid,
  input logic              ovClear
);

  logic accepted;
  assign accepted = instValid && (instWord[23:19] == 5'b11010);

  AST_VALID_FROM_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(accepted)); // R1

  AST_PC_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(pcNext)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (pcNext == PC_W'($past(pcIn) + PC_W'(1))) ||
                 (pcNext == PC_W'($past(pcIn) + PC_W'(2)))); // R10

  AST_INVERT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && instWord[17] && instWord[12:8] == 5'b0 && instWord[7:0] == 8'b0)
      |=> pcNext == PC_W'($past(pcIn) + PC_W'(2))); // R9

  AST_EMPTY_NO_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !instWord[17] && instWord[12:8] == 5'b0 && instWord[7:0] == 8'b0)
      |=> pcNext == PC_W'($past(pcIn) + PC_W'(1))); // R8

  AST_OV_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rstN)
    ovClear |-> $past(accepted && instWord[11])); // R11

  AST_OV_CLEAR_DUE: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && instWord[11]) |=> ovClear); // R11

  AST_OV_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ovClear |-> resultValid); // R11

  logic unusedInputs;
  assign unusedInputs = ^{acc, ioReg, ovFlag, senseSw};

endmodule

bind skip_eval_top skip_eval_chk #(.WORD_W(WORD_W), .PC_W(PC_W), .SW_W(SW_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .instValid  (instValid),
  .instWord   (instWord),
  .acc        (acc),
  .ioReg      (ioReg),
  .ovFlag     (ovFlag),
  .senseSw    (senseSw),
  .pcIn       (pcIn),
  .pcNext     (pcNext),
  .resultValid(resultValid),
  .ovClear    (ovClear)
);

// File: tb/skip_eval_tb_top.sv
`timescale 1ns/1ps
module skip_eval_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [23:0] instWord;
  logic [23:0] acc;
  logic [23:0] ioReg;
  logic        ovFlag;
  logic [7:0]  senseSw;
  logic [15:0] pcIn;
  logic [15:0] pcNext;
  logic        resultValid;
  logic        ovClear;

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 0;

  always #2.5 clk = ~clk;

  skip_eval_top dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .acc(acc), .ioReg(ioReg), .ovFlag(ovFlag), .senseSw(senseSw),
    .pcIn(pcIn), .pcNext(pcNext), .resultValid(resultValid), .ovClear(ovClear)
  );

  // Builds a skip-class word. cond bits: [4] IO>=0, [3] OV==0,
  // [2] AC<0, [1] AC>=0, [0] AC==0.
  function automatic logic [23:0] mkSkip(input logic inv, input logic [4:0] cond,
                                         input logic [7:0] sw);
    return {5'b11010, 1'b0, inv, 4'b0000, cond, sw};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Presents one instruction, checks the result cycle, then checks
  // that the strobes drop and pcNext holds one cycle later.
  task automatic runInst(input string req, input logic valid, input logic [23:0] w,
                         input logic [23:0] a, input logic [23:0] io, input logic ov,
                         input logic [7:0] sw, input logic [15:0] pc,
                         input logic expValid, input logic [15:0] expPc,
                         input logic expOvClr);
    @(negedge clk);
    instValid = valid; instWord = w; acc = a; ioReg = io;
    ovFlag = ov; senseSw = sw; pcIn = pc;
    @(posedge clk); #1;
    check(req, "resultValid", 32'(resultValid), 32'(expValid));
    check(req, "pcNext", 32'(pcNext), 32'(expPc));
    check(req, "ovClear", 32'(ovClear), 32'(expOvClr));
    @(negedge clk);
    instValid = 1'b0; pcIn = pc ^ 16'h5A5A;
    @(posedge clk); #1;
    check(req, "valid drop", 32'(resultValid), 32'h0);
    check(req, "ovClear drop", 32'(ovClear), 32'h0);
    check(req, "pcNext hold", 32'(pcNext), 32'(expPc));
  endtask

  task automatic tReset();
    check("R12", "reset valid", 32'(resultValid), 32'h0);
    check("R12", "reset pc", 32'(pcNext), 32'h0);
    check("R12", "reset ovClear", 32'(ovClear), 32'h0);
  endtask

  task automatic tAccZero();
    runInst("R2", 1, mkSkip(0, 5'b00001, 8'h00), 24'h0, 24'h800000, 1, 8'h00, 16'd100, 1, 16'd102, 0);
    runInst("R2", 1, mkSkip(0, 5'b00001, 8'h00), 24'h5, 24'h0, 0, 8'hFF, 16'd100, 1, 16'd101, 0);
  endtask

  task automatic tAccSign();
    runInst("R3", 1, mkSkip(0, 5'b00010, 8'h00), 24'h000001, 24'h800000, 1, 8'h00, 16'd200, 1, 16'd202, 0);
    runInst("R3", 1, mkSkip(0, 5'b00010, 8'h00), 24'h800000, 24'h0, 1, 8'h00, 16'd200, 1, 16'd201, 0);
    runInst("R4", 1, mkSkip(0, 5'b00100, 8'h00), 24'hFFFFFF, 24'h0, 1, 8'h00, 16'd300, 1, 16'd302, 0);
    runInst("R4", 1, mkSkip(0, 5'b00100, 8'h00), 24'h000000, 24'h800000, 1, 8'h00, 16'd300, 1, 16'd301, 0);
  endtask

  task automatic tOverflow();
    runInst("R5", 1, mkSkip(0, 5'b01000, 8'h00), 24'h800001, 24'h800000, 0, 8'h00, 16'd400, 1, 16'd402, 1);
    runInst("R11", 1, mkSkip(0, 5'b01000, 8'h00), 24'h0, 24'h0, 1, 8'h00, 16'd400, 1, 16'd401, 1);
  endtask

  task automatic tIo();
    runInst("R6", 1, mkSkip(0, 5'b10000, 8'h00), 24'h800000, 24'h7FFFFF, 1, 8'h00, 16'd500, 1, 16'd502, 0);
    runInst("R6", 1, mkSkip(0, 5'b10000, 8'h00), 24'h0, 24'h800000, 0, 8'h00, 16'd500, 1, 16'd501, 0);
  endtask

  task automatic tSwitch();
    runInst("R7", 1, mkSkip(0, 5'b00000, 8'h20), 24'h1, 24'h800000, 1, 8'h20, 16'd600, 1, 16'd602, 0);
    runInst("R7", 1, mkSkip(0, 5'b00000, 8'h20), 24'h1, 24'h800000, 1, 8'hDF, 16'd600, 1, 16'd601, 0);
    runInst("R7", 1, mkSkip(0, 5'b00000, 8'h01), 24'h1, 24'h800000, 1, 8'h01, 16'd610, 1, 16'd612, 0);
  endtask

  task automatic tOrCombine();
    runInst("R8", 1, mkSkip(0, 5'b00101, 8'h80), 24'h000003, 24'h0, 1, 8'h80, 16'd700, 1, 16'd702, 0);
    runInst("R8", 1, mkSkip(0, 5'b10101, 8'h0F), 24'h000003, 24'h800000, 1, 8'hF0, 16'd700, 1, 16'd701, 0);
    runInst("R8", 1, mkSkip(0, 5'b00000, 8'h00), 24'h0, 24'h0, 0, 8'hFF, 16'd710, 1, 16'd711, 0);
  endtask

  task automatic tInvert();
    runInst("R9", 1, mkSkip(1, 5'b00000, 8'h00), 24'h5, 24'h800000, 1, 8'h00, 16'd800, 1, 16'd802, 0);
    runInst("R9", 1, mkSkip(1, 5'b00001, 8'h00), 24'h0, 24'h0, 1, 8'h00, 16'd800, 1, 16'd801, 0);
    runInst("R9", 1, mkSkip(1, 5'b01000, 8'h00), 24'h0, 24'h0, 1, 8'h00, 16'd810, 1, 16'd812, 1);
  endtask

  task automatic tWrap();
    runInst("R10", 1, mkSkip(1, 5'b00000, 8'h00), 24'h0, 24'h0, 0, 8'h00, 16'hFFFF, 1, 16'h0001, 0);
    runInst("R10", 1, mkSkip(0, 5'b00000, 8'h00), 24'h0, 24'h0, 0, 8'h00, 16'hFFFF, 1, 16'h0000, 0);
    runInst("R10", 1, mkSkip(0, 5'b00001, 8'h00), 24'h0, 24'h0, 0, 8'h00, 16'hFFFE, 1, 16'h0000, 0);
  endtask

  task automatic tNonGroup();
    // Establish a known pcNext first.
    runInst("R1", 1, mkSkip(0, 5'b00001, 8'h00), 24'h0, 24'h0, 0, 8'h00, 16'd900, 1, 16'd902, 0);
    // Wrong opcode 11011, selects all set: no result, pc held.
    runInst("R1", 1, {5'b11011, 19'h7FFFF}, 24'h0, 24'h0, 0, 8'hFF, 16'd1000, 0, 16'd902, 0);
    // Group word with instValid low.
    runInst("R1", 0, mkSkip(1, 5'b11111, 8'hFF), 24'h0, 24'h0, 0, 8'hFF, 16'd1100, 0, 16'd902, 0);
    // Bit 5 set is still the skip class.
    runInst("R1", 1, mkSkip(0, 5'b00001, 8'h00) | 24'h040000, 24'h0, 24'h0, 1, 8'h00, 16'd1200, 1, 16'd1202, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      testsFail++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; instValid = 1'b0; instWord = '0; acc = '0; ioReg = '0;
    ovFlag = 1'b0; senseSw = '0; pcIn = '0;
    repeat (3) @(posedge clk);
    #1;
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    tReset();
    tAccZero();
    tAccSign();
    tOverflow();
    tIo();
    tSwitch();
    tOrCombine();
    tInvert();
    tWrap();
    tNonGroup();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule